// File: doc/BRIEF.md
# Quad-Phase Sampling Time-to-Digital Converter Channel

This block timestamps every rising and every falling edge of one asynchronous input line. The line is captured by four flip-flops, each clocked by one of four phases (0°, 90°, 180°, 270°) of a fast clock. Each sample then passes through three more registers in its own phase domain. The last two of those stages hold two consecutive fast periods. A half-rate clock, whose rising edges line up with phase 0, gathers all eight samples at once into one window. That window covers eight bins of a quarter fast period each.

Within a window, the position of the first level change is encoded as a 3-bit fine count. The change may also fall between the last sample of the previous window and the first sample of this one. The fine count is joined with the edge direction, a multi-transition marker and a 14-bit coarse count of half-rate periods, and the resulting hit word is written into a small buffer. Software-independent readers drain the buffer through a show-ahead read port in the half-rate domain. A hit that finds the buffer full is dropped and counted.

Top module: `qphase_tdc_channel`

## Requirements
- R1: The fine field (word bits [2:0]) gives the index of the first sample that differs from its predecessor. Samples are indexed 0..7 in the order phase 0, 90, 180, 270 of the earlier fast period, then the same four phases of the later period.
- R2: Word bit 3 is 1 when the recorded transition goes from low to high, and 0 when it goes from high to low.
- R3: A window whose eight samples all equal the last sample of the previous window produces no hit. A change between that last sample and sample 0 is a hit with fine index 0.
- R4: When a window holds more than one transition, only the first is recorded, and word bit 18 is set. With a single transition, bit 18 is 0.
- R5: Word bits [17:4] hold the window number modulo 2^14. Window 0 is the one starting at the last half-rate rising edge at or before reset release, and the count wraps without any indication.
- R6: A window's hit appears at the read port right after the second half-rate rising edge that follows the end of that window.
- R7: The buffer returns hits in arrival order, and the oldest stored hit is always shown on `hit_word`. A rising edge with `rd_en` high removes the shown hit. `rd_en` has no effect while the buffer is empty.
- R8: A hit that arrives while the buffer holds DEPTH (8) entries, with `rd_en` low, is discarded, and `lost_cnt` increments. `lost_cnt` saturates at 255.
- R9: A hit that arrives at the same edge as a read of a full buffer is stored, and `lost_cnt` does not change.
- R10: Reset empties the buffer, clears `lost_cnt` and the coarse count, and clears all sample registers so that the input is seen as low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ph | input | 4 | Fast clock phases; bit k lags bit 0 by k quarter periods |
| clk_half | input | 1 | Half-rate clock, rising edges aligned with phase 0 |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| din | input | 1 | Asynchronous input whose edges are timed |
| rd_en | input | 1 | Removes the shown hit at the next half-rate edge |
| hit_word | output | 19 | Oldest stored hit: {multi, coarse[13:0], rising, fine[2:0]} |
| hit_empty | output | 1 | High when the buffer holds no hit |
| lost_cnt | output | 8 | Saturating count of discarded hits |

## Verification
Two functions can fall on the same half-rate edge: a new hit entering the buffer and a read removing the oldest entry. The most telling case is when the buffer is full. The bench produces one hit per window while reads are held off, so the buffer fills and overflow starts. It then raises `rd_en` for exactly one edge in the middle of that stream. The case is judged by `lost_cnt` staying at its prior value across that edge, and by the window's word later appearing in order when the buffer drains. The per-edge reference model also compares every field of the shown word on every cycle.

// File: rtl/qphase_tdc_channel.sv
module qphase_tdc_channel #(
  parameter int CW    = 14,
  parameter int DEPTH = 8,
  parameter int LW    = 8
) (
  input  logic [3:0]    clk_ph,
  input  logic          clk_half,
  input  logic          rst_n,
  input  logic          din,
  input  logic          rd_en,
  output logic [CW+4:0] hit_word,
  output logic          hit_empty,
  output logic [LW-1:0] lost_cnt
);
  localparam int NPH = 4;
  localparam int WIN = 2 * NPH;
  localparam int FW  = $clog2(WIN);
  localparam int WW  = CW + FW + 2;
  localparam int AW  = $clog2(DEPTH);

  logic [WIN-1:0] win_now;

  genvar g;
  generate
    for (g = 0; g < NPH; g++) begin : g_ph
      logic [3:0] pipe;
      always_ff @(posedge clk_ph[g] or negedge rst_n)
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[2:0], din};
      assign win_now[g]     = pipe[3];
      assign win_now[g+NPH] = pipe[2];
    end
  endgenerate

  logic [WIN-1:0] win_r;
  logic           last_r;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk_half or negedge rst_n)
    if (!rst_n) begin
      win_r  <= '0;
      last_r <= 1'b0;
      cnt_q  <= '0;
    end else begin
      win_r  <= win_now;
      last_r <= win_r[WIN-1];
      cnt_q  <= cnt_q + 1'b1;
    end

  logic [WIN-1:0] trans, below_mask;
  logic           hit_v, multi_w, edge_w, prev_bit;
  logic [FW-1:0]  fine_w;
  logic [CW-1:0]  stamp;
  logic [WW-1:0]  new_word;

  assign trans   = win_r ^ {win_r[WIN-2:0], last_r};
  assign hit_v   = |trans;
  assign multi_w = |(trans & (trans - 1'b1));

  always_comb begin
    fine_w = '0;
    for (int i = WIN - 1; i >= 0; i--)
      if (trans[i]) fine_w = FW'(i);
  end

  assign edge_w     = win_r[fine_w];
  assign prev_bit   = (fine_w == '0) ? last_r : win_r[fine_w - 1'b1];
  assign below_mask = (WIN'(1) << fine_w) - WIN'(1);
  assign stamp      = cnt_q - CW'(2);
  assign new_word   = {multi_w, stamp, edge_w, fine_w};

  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fill;
  logic [LW-1:0] lost_q;
  logic          full, rd_do, wr_do;

  assign full      = fill == (AW+1)'(DEPTH);
  assign hit_empty = fill == '0;
  assign rd_do     = rd_en && !hit_empty;
  assign wr_do     = hit_v && (!full || rd_en);
  assign hit_word  = mem[rp];
  assign lost_cnt  = lost_q;

  always_ff @(posedge clk_half)
    if (wr_do) mem[wp] <= new_word;

  always_ff @(posedge clk_half or negedge rst_n)
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      fill   <= '0;
      lost_q <= '0;
    end else begin
      if (wr_do) wp <= wp + 1'b1;
      if (rd_do) rp <= rp + 1'b1;
      fill <= fill + (AW+1)'(wr_do) - (AW+1)'(rd_do);
      if (hit_v && !wr_do && lost_q != '1) lost_q <= lost_q + 1'b1;
    end

  AST_FIRST_TRANSITION: assert property (@(posedge clk_half) disable iff (!rst_n)
    hit_v |-> ((win_r & below_mask) == (last_r ? below_mask : '0)) && (edge_w != prev_bit)); // R1
  AST_SINGLE_EDGE_LEVEL: assert property (@(posedge clk_half) disable iff (!rst_n)
    (hit_v && !multi_w) |-> (win_r[WIN-1] == edge_w)); // R2
  AST_QUIET_WINDOW: assert property (@(posedge clk_half) disable iff (!rst_n)
    !hit_v |-> (win_r == {WIN{last_r}})); // R3
  AST_FILL_BOUND: assert property (@(posedge clk_half) disable iff (!rst_n)
    fill <= (AW+1)'(DEPTH)); // R7
  AST_DROP_COUNTED: assert property (@(posedge clk_half) disable iff (!rst_n)
    (hit_v && full && !rd_en && lost_q != '1) |=> (lost_q == LW'($past(lost_q) + 1'b1))); // R8
  AST_FULL_SWAP: assert property (@(posedge clk_half) disable iff (!rst_n)
    (hit_v && full && rd_en) |=> (full && $stable(lost_q))); // R9
endmodule

// File: tb/qphase_tdc_channel_tb_top.sv
`timescale 1ns/1ps
module qphase_tdc_channel_tb_top;
  localparam int NW    = 16420;
  localparam int DEPTH = 8;
  localparam int ENDE  = 16410;

  logic [3:0]  clk_ph = 4'b0;
  logic        clk_h = 1'b0;
  logic        rst_n = 1'b0;
  logic        din = 1'b0;
  logic        rd_en = 1'b0;
  logic [18:0] hit_word;
  logic        hit_empty;
  logic [7:0]  lost_cnt;

  qphase_tdc_channel dut_i (
    .clk_ph(clk_ph), .clk_half(clk_h), .rst_n(rst_n), .din(din), .rd_en(rd_en),
    .hit_word(hit_word), .hit_empty(hit_empty), .lost_cnt(lost_cnt)
  );

  logic [7:0]  pat [NW];
  logic [18:0] mq [$];
  int checks = 0, failures = 0, ecnt = 0, mlost = 0, lost_prev = 0;
  bit done = 0, saw_wrap = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic sched(int e);
    if (e >= 150 && e < 600 && e != 400) return 1'b0;
    if (e >= 16395) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    for (int w = 0; w < NW; w++) pat[w] = 8'h00;
    for (int i = 0; i < 8; i++) begin
      pat[10+4*i] = 8'hFF << i;
      pat[11+4*i] = 8'hFF;
      pat[12+4*i] = ~(8'hFF << i);
      pat[13+4*i] = 8'h00;
    end
    pat[50] = 8'h3C; pat[52] = 8'h04; pat[54] = 8'hFE; pat[55] = 8'h01; pat[57] = 8'hAA;
    for (int w = 200; w < 520; w++) pat[w] = (w % 2 == 0) ? 8'hF0 : 8'h0F;
    pat[16382] = 8'hC0; pat[16384] = 8'h80;
    pat[16400] = 8'hF0; pat[16401] = 8'h0F;
  end

  // tick = 1.25 ns; phase k rises at tick 2k mod 8; half clock rises at tick 0 mod 16
  initial begin
    int tick;
    tick = 0;
    forever begin
      for (int k = 0; k < 4; k++) clk_ph[k] = (((tick + 8 - 2*k) % 8) < 4);
      clk_h = ((tick % 16) < 8);
      if (tick % 2 == 1) begin
        int n;
        n = (tick + 1) / 2;
        if (n >= 40) begin
          int w;
          w = (n - 40) / 8;
          din = (w < NW) ? pat[w][(n-40)%8] : 1'b0;
        end
      end
      #1.25;
      tick++;
    end
  end

  always @(posedge clk_h) begin
    if (rst_n && !done) begin
      int w;
      ecnt++;
      if (rd_en && mq.size() > 0) void'(mq.pop_front());
      w = ecnt - 3;
      if (w >= 0 && w < NW) begin
        logic prv, cur, bef, ed;
        int nt, fi;
        prv = (w > 0) ? pat[w-1][7] : 1'b0;
        nt = 0; fi = 0; ed = 1'b0;
        for (int i = 0; i < 8; i++) begin
          cur = pat[w][i];
          bef = (i == 0) ? prv : pat[w][i-1];
          if (cur != bef) begin
            nt++;
            if (nt == 1) begin fi = i; ed = cur; end
          end
        end
        if (nt > 0) begin
          if (mq.size() < DEPTH) mq.push_back({(nt > 1), 14'(w % 16384), ed, 3'(fi)});
          else if (mlost < 255) mlost++;
        end
      end
    end
  end

  always @(negedge clk_h) begin
    if (rst_n && !done) begin
      if (ecnt >= 1) begin
        check(hit_empty == (mq.size() == 0), "R3 R6 R7 presence", hit_empty, mq.size() == 0);
        if (!hit_empty && mq.size() > 0) begin
          check(hit_word[2:0] == mq[0][2:0], "R1 fine", hit_word[2:0], mq[0][2:0]);
          check(hit_word[3] == mq[0][3], "R2 edge", hit_word[3], mq[0][3]);
          check(hit_word[17:4] == mq[0][17:4], "R5 coarse", hit_word[17:4], mq[0][17:4]);
          check(hit_word[18] == mq[0][18], "R4 multi", hit_word[18], mq[0][18]);
          if (ecnt > 16000 && mq[0][17:4] == 14'd0 && mq[0][2:0] == 3'd7) saw_wrap = 1;
        end
        check(lost_cnt == 8'(mlost), "R8 lost", lost_cnt, mlost);
      end
      if (ecnt == 399) lost_prev = lost_cnt;
      if (ecnt == 400) begin
        check(lost_cnt == 8'(lost_prev), "R9 lost unchanged", lost_cnt, lost_prev);
        check(!hit_empty, "R9 buffer kept", hit_empty, 0);
      end
      rd_en = sched(ecnt + 1);
    end
  end

  initial begin
    #50;
    check(hit_empty == 1'b1, "R10 reset empty", hit_empty, 1);
    check(lost_cnt == 8'd0, "R10 reset lost", lost_cnt, 0);
    #56.25;
    rst_n = 1'b1;
    wait (ecnt == ENDE);
    @(negedge clk_h);
    #1;
    done = 1;
    check(!hit_empty, "R10 preload", hit_empty, 0);
    check(lost_cnt == 8'd255, "R8 saturation", lost_cnt, 255);
    check(saw_wrap, "R5 wrap seen", saw_wrap, 1);
    rst_n = 1'b0;
    #3;
    check(hit_empty == 1'b1, "R10 reset clears buffer", hit_empty, 1);
    check(lost_cnt == 8'd0, "R10 reset clears lost", lost_cnt, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", ecnt, ENDE);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule